// File: doc/BRIEF.md
# Floating-point status field-write unit

This block holds a 64-bit floating-point status and control register made of sixteen 4-bit fields. It carries out two write commands that it decodes from a 32-bit instruction word. The register-source command merges a 64-bit operand into the register under an 8-bit field mask. The immediate command places one 4-bit constant into a single field. The execute stage presents a command with a one-cycle strobe. The unit then updates the register, or it raises a one-cycle error pulse and leaves the register alone.

Two bits of the register are summaries and cannot be written directly. Bit 29 is the invalid-operation summary and bit 30 is the enabled-exception summary. After every write the unit recomputes both from the sticky and enable bits. A build parameter sets the register size. In wide mode all sixteen fields exist, and a half-select bit moves the field mask onto the upper eight fields. In narrow mode only the lower 32 bits exist, and setting the half-select bit is an illegal instruction.

Top module: `fsr_field_writer`

## Requirements
- R1: After reset `status_o` is all zeros, and `illegal_o` and `unavail_o` are low.
- R2: A word with bits 31..26 = 63 and bits 10..1 = 711 is the register-source command. Its field mask is at bits 24..17. Mask bit i replaces register bits 4i+3..4i with the same bits of `src_i`. Every field whose mask bit is clear keeps its contents.
- R3: The half-select bit is instruction bit 16. In wide mode, setting it in the register-source command shifts the field mask left by eight, so mask bit i addresses field i+8.
- R4: Setting bit 25 in the register-source command ignores the field mask and writes every field: all sixteen in wide mode, fields 0..7 in narrow mode.
- R5: A word with bits 31..26 = 63 and bits 10..1 = 134 is the immediate command. The field number f is at bits 21..19 and the constant is at bits 15..12. The constant replaces field 8*h + 7 - f, where h is bit 16. No other field changes.
- R6: Register bits 30 and 29 are never taken from the written value. After each write, bit 29 becomes the OR of bits 24..19 and 10..8. Bit 30 then becomes the OR of the five pairs (29,7), (28,6), (27,5), (26,4) and (25,3), each pair ANDed, using the new bit 29.
- R7: A recognised command that arrives while `fpu_en_i` is low raises `unavail_o` and performs no write. This check comes before the half-select check, so `illegal_o` stays low.
- R8: In narrow mode, a recognised command with bit 16 set raises `illegal_o` and performs no write.
- R9: In narrow mode, bits 63..32 of `status_o` always read zero.
- R10: The result of a command accepted at a clock edge is visible after that edge. An error pulse lasts one cycle. The register does not change in a cycle without `valid_i`, and back-to-back commands each take effect.
- R11: A strobed word that matches neither command causes no write and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command strobe, one cycle per command |
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Operand for the register-source command |
| fpu_en_i | input | 1 | Floating-point unit enabled |
| status_o | output | 64 | Status and control register |
| illegal_o | output | 1 | Illegal-instruction pulse |
| unavail_o | output | 1 | Unit-unavailable pulse |

## Verification
The bench drives a wide instance and a narrow instance with the same commands. The half-select and all-fields cases then show both a remapped mask and an illegal pulse from a single stimulus. A design that lets bits 30..29 follow the operand, or that skips the recompute, shows wrong summary bits after the operand sets them and after sticky bits are set and later cleared. A design that checks half-select before the enable raises the wrong error when both apply at once. A design that reverses the immediate field numbering puts the constant into the mirrored field, and this shows at field numbers 0, 2 and 7.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned FIELDS   = REG_W / NIB_W;
  localparam int unsigned HALF_F   = FIELDS / 2;
  localparam int unsigned FLM_W    = 8;
  localparam int unsigned BF_W     = 3;
  localparam int unsigned SH_W     = BF_W + 1;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned XO_W     = 10;

  localparam logic [OPC_W-1:0] OPC_FP   = 6'd63;
  localparam logic [XO_W-1:0]  XO_REG   = 10'd711;
  localparam logic [XO_W-1:0]  XO_IMM   = 10'd134;

  localparam int unsigned VX_BIT   = 29;
  localparam int unsigned FEX_BIT  = 30;
  localparam int unsigned EXC_N    = 5;
  localparam int unsigned EN_HI    = 7;
  localparam logic [REG_W-1:0] PROT_MASK = 64'h0000_0000_6000_0000;
  localparam logic [REG_W-1:0] VX_SRC    = 64'h0000_0000_01F8_0700;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_REG  = 2'd1,
    CMD_IMM  = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output cmd_kind_e         kind_o,
  output logic              half_o,
  output logic              all_o,
  output logic [FLM_W-1:0]  flm_o,
  output logic [BF_W-1:0]   bf_o,
  output logic [NIB_W-1:0]  imm_o
);
  logic [OPC_W-1:0] opc;
  logic [XO_W-1:0]  xo;
  logic             unused_bits;

  assign opc         = insn_i[31:26];
  assign xo          = insn_i[10:1];
  assign half_o      = insn_i[16];
  assign all_o       = insn_i[25];
  assign flm_o       = insn_i[24:17];
  assign bf_o        = insn_i[21:19];
  assign imm_o       = insn_i[15:12];
  assign unused_bits = ^{insn_i[11], insn_i[0]};

  always_comb begin
    kind_o = CMD_NONE;
    if (opc == OPC_FP) begin
      if (xo == XO_REG)      kind_o = CMD_REG;
      else if (xo == XO_IMM) kind_o = CMD_IMM;
    end
  end
endmodule

// File: rtl/fsr_cmd_gen.sv
module fsr_cmd_gen
  import fsr_pkg::*;
#(
  parameter bit WIDE_EN = 1'b1
) (
  input  cmd_kind_e         kind_i,
  input  logic              half_i,
  input  logic              all_i,
  input  logic [FLM_W-1:0]  flm_i,
  input  logic [BF_W-1:0]   bf_i,
  input  logic [NIB_W-1:0]  imm_i,
  input  logic [REG_W-1:0]  src_i,
  output logic [FIELDS-1:0] mask_o,
  output logic [REG_W-1:0]  data_o
);
  localparam logic [FIELDS-1:0] ALL_MASK = WIDE_EN ? {FIELDS{1'b1}}
                                                   : {{HALF_F{1'b0}}, {HALF_F{1'b1}}};
  logic [SH_W-1:0]   sh;
  logic [FIELDS-1:0] mask_raw;

  // field = 8*half + 7 - bf; 7 - bf is the bitwise inverse on 3 bits
  assign sh = {half_i, ~bf_i};

  always_comb begin
    mask_raw = '0;
    data_o   = src_i;
    unique case (kind_i)
      CMD_REG: begin
        if (all_i)       mask_raw = ALL_MASK;
        else if (half_i) mask_raw = {flm_i, {HALF_F{1'b0}}};
        else             mask_raw = {{HALF_F{1'b0}}, flm_i};
      end
      CMD_IMM: begin
        mask_raw = FIELDS'(1) << sh;
        data_o   = REG_W'(imm_i) << {sh, 2'b00};
      end
      default: mask_raw = '0;
    endcase
  end

  if (WIDE_EN) begin : g_wide
    assign mask_o = mask_raw;
  end else begin : g_narrow
    assign mask_o = {{HALF_F{1'b0}}, mask_raw[HALF_F-1:0]};
  end
endmodule

// File: rtl/fsr_merge.sv
module fsr_merge
  import fsr_pkg::*;
(
  input  logic [REG_W-1:0]  old_i,
  input  logic [REG_W-1:0]  data_i,
  input  logic [FIELDS-1:0] mask_i,
  output logic [REG_W-1:0]  merged_o
);
  logic [REG_W-1:0] cand;

  // summary bits always come from the old value; recomputed later
  assign cand = (data_i & ~PROT_MASK) | (old_i & PROT_MASK);

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    assign merged_o[f*NIB_W +: NIB_W] = mask_i[f] ? cand[f*NIB_W +: NIB_W]
                                                  : old_i[f*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/fsr_summary.sv
module fsr_summary
  import fsr_pkg::*;
(
  input  logic [REG_W-1:0] raw_i,
  output logic [REG_W-1:0] fixed_o
);
  logic             vx;
  logic [EXC_N-1:0] exc;
  logic [EXC_N-1:0] ena;
  logic             fex;

  assign vx  = |(raw_i & VX_SRC);
  assign exc = {vx, raw_i[VX_BIT-1 -: EXC_N-1]};
  assign ena = raw_i[EN_HI -: EXC_N];
  assign fex = |(exc & ena);

  always_comb begin
    fixed_o          = raw_i;
    fixed_o[VX_BIT]  = vx;
    fixed_o[FEX_BIT] = fex;
  end
endmodule

// File: rtl/fsr_field_writer.sv
module fsr_field_writer
  import fsr_pkg::*;
#(
  parameter bit WIDE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [REG_W-1:0]  src_i,
  input  logic              fpu_en_i,
  output logic [REG_W-1:0]  status_o,
  output logic              illegal_o,
  output logic              unavail_o
);
  cmd_kind_e         kind;
  logic              half, all_f;
  logic [FLM_W-1:0]  flm;
  logic [BF_W-1:0]   bf;
  logic [NIB_W-1:0]  imm;
  logic [FIELDS-1:0] mask;
  logic [REG_W-1:0]  data, merged, next_s;
  logic [REG_W-1:0]  status_q;
  logic              is_cmd, half_bad, unav_d, ill_d, wr_en;

  fsr_decode u_dec (
    .insn_i (insn_i),
    .kind_o (kind),
    .half_o (half),
    .all_o  (all_f),
    .flm_o  (flm),
    .bf_o   (bf),
    .imm_o  (imm)
  );

  fsr_cmd_gen #(.WIDE_EN(WIDE_EN)) u_gen (
    .kind_i (kind),
    .half_i (half),
    .all_i  (all_f),
    .flm_i  (flm),
    .bf_i   (bf),
    .imm_i  (imm),
    .src_i  (src_i),
    .mask_o (mask),
    .data_o (data)
  );

  fsr_merge u_mrg (
    .old_i    (status_q),
    .data_i   (data),
    .mask_i   (mask),
    .merged_o (merged)
  );

  fsr_summary u_sum (
    .raw_i   (merged),
    .fixed_o (next_s)
  );

  assign is_cmd   = valid_i && (kind != CMD_NONE);
  assign half_bad = half && !WIDE_EN;
  // disabled unit wins over the half-select check
  assign unav_d   = is_cmd && !fpu_en_i;
  assign ill_d    = is_cmd && fpu_en_i && half_bad;
  assign wr_en    = is_cmd && fpu_en_i && !half_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= '0;
      illegal_o <= 1'b0;
      unavail_o <= 1'b0;
    end else begin
      illegal_o <= ill_d;
      unavail_o <= unav_d;
      if (wr_en) status_q <= next_s;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/fsr_field_writer_chk.sv
module fsr_field_writer_chk #(
  parameter bit WIDE_EN = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        fpu_en_i,
  input logic [63:0] status_o,
  input logic        illegal_o,
  input logic        unavail_o
);
  // R6
  vx_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[29] == ((|status_o[24:19]) || (|status_o[10:8])));

  // R6
  fex_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[30] == (|(status_o[29:25] & status_o[7:3])));

  // R7
  unavail_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |-> ($past(valid_i) && !$past(fpu_en_i) && !illegal_o));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o || unavail_o) |-> $stable(status_o));

  // R8
  illegal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!WIDE_EN && $past(valid_i) && $past(fpu_en_i)));

  // R9
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WIDE_EN |-> (status_o[63:32] == 32'h0));

  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(status_o) && !illegal_o && !unavail_o));
endmodule

bind fsr_field_writer fsr_field_writer_chk #(.WIDE_EN(WIDE_EN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .fpu_en_i  (fpu_en_i),
  .status_o  (status_o),
  .illegal_o (illegal_o),
  .unavail_o (unavail_o)
);

// File: tb/fsr_field_writer_tb_top.sv
`timescale 1ns/1ps
module fsr_field_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_i = '0;
  logic        fpu_en_i = 1'b1;
  logic [63:0] st_w, st_n;
  logic        ill_w, ill_n, una_w, una_n;

  int checks = 0;
  int fails  = 0;
  logic [63:0] mw = '0;
  logic [63:0] mn = '0;

  typedef struct {
    logic [63:0] st;
    logic        ill;
    logic        una;
    string       req;
  } exp_t;
  exp_t wq[$];
  exp_t nq[$];

  always #4 clk = ~clk;

  fsr_field_writer #(.WIDE_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .src_i(src_i), .fpu_en_i(fpu_en_i),
    .status_o(st_w), .illegal_o(ill_w), .unavail_o(una_w));

  fsr_field_writer #(.WIDE_EN(1'b0)) dut_n_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .src_i(src_i), .fpu_en_i(fpu_en_i),
    .status_o(st_n), .illegal_o(ill_n), .unavail_o(una_n));

  task automatic check(input string req, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic wide, input logic [31:0] insn,
                                 input logic [63:0] src, input logic en,
                                 input logic [63:0] old);
    exp_t r;
    logic rs, im, h;
    logic [15:0] m;
    logic [63:0] d, nv;
    int sh;
    r.st = old; r.ill = 1'b0; r.una = 1'b0; r.req = "";
    rs = (insn[31:26] == 6'd63) && (insn[10:1] == 10'd711);
    im = (insn[31:26] == 6'd63) && (insn[10:1] == 10'd134);
    h  = insn[16];
    if (!(rs || im)) return r;
    if (!en) begin r.una = 1'b1; return r; end
    if (h && !wide) begin r.ill = 1'b1; return r; end
    if (rs) begin
      d = src;
      if (insn[25]) m = wide ? 16'hFFFF : 16'h00FF;
      else m = h ? {insn[24:17], 8'h00} : {8'h00, insn[24:17]};
    end else begin
      sh = (h ? 8 : 0) + 7 - int'(insn[21:19]);
      d  = 64'(insn[15:12]) << (4 * sh);
      m  = 16'(1) << sh;
    end
    if (!wide) m[15:8] = 8'h00;
    nv = old;
    for (int i = 0; i < 16; i++) if (m[i]) nv[4*i +: 4] = d[4*i +: 4];
    nv[30:29] = old[30:29];
    nv[29] = (|nv[24:19]) | (|nv[10:8]);
    nv[30] = (nv[29] & nv[7]) | (nv[28] & nv[6]) | (nv[27] & nv[5]) |
             (nv[26] & nv[4]) | (nv[25] & nv[3]);
    r.st = nv;
    return r;
  endfunction

  function automatic logic [31:0] rs_insn(input logic all_f, input logic [7:0] flm,
                                          input logic h);
    return {6'd63, all_f, flm, h, 5'd0, 10'd711, 1'b0};
  endfunction

  function automatic logic [31:0] im_insn(input logic [2:0] bf, input logic [3:0] imm,
                                          input logic h);
    return {6'd63, 4'd0, bf, 2'd0, h, imm, 1'b0, 10'd134, 1'b0};
  endfunction

  // driver: one command per negedge, expected results to the scoreboard
  task automatic cmd(input string req, input logic [31:0] insn,
                     input logic [63:0] src, input logic en);
    exp_t ew, en_;
    @(negedge clk);
    insn_i = insn; src_i = src; fpu_en_i = en; valid_i = 1'b1;
    ew = model(1'b1, insn, src, en, mw); ew.req = req;
    en_ = model(1'b0, insn, src, en, mn); en_.req = req;
    mw = ew.st; mn = en_.st;
    wq.push_back(ew); nq.push_back(en_);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; fpu_en_i = 1'b1;
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    logic popped = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (wq.size() > 0) begin
        e = wq.pop_front();
        check(e.req, "wide", {st_w, ill_w, una_w}, {e.st, e.ill, e.una});
        e = nq.pop_front();
        check(e.req, "narrow", {st_n, ill_n, una_n}, {e.st, e.ill, e.una});
        popped = 1'b1;
      end else if (popped) begin
        // R10 error pulses last one cycle
        check("R10", "pulse end", {64'h0, ill_w | ill_n, una_w | una_n}, 66'h0);
        popped = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    // R1
    check("R1", "reset wide", {st_w, ill_w, una_w}, 66'h0);
    check("R1", "reset narrow", {st_n, ill_n, una_n}, 66'h0);
    rst_ni = 1'b1;
    idle(2);

    cmd("R2", rs_insn(1'b0, 8'h81, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    cmd("R2", rs_insn(1'b0, 8'h3C, 1'b0), 64'h0123_4567_89AB_CDEF, 1'b1);
    idle(2);
    cmd("R3", rs_insn(1'b0, 8'hA5, 1'b1), 64'hFEDC_BA98_7654_3210, 1'b1);
    idle(2);
    cmd("R4", rs_insn(1'b1, 8'h00, 1'b0), 64'h5555_AAAA_3333_CCCC, 1'b1);
    idle(2);
    cmd("R8", rs_insn(1'b1, 8'h00, 1'b1), 64'hFFFF_0000_FFFF_0000, 1'b1);
    idle(2);
    cmd("R5", im_insn(3'd0, 4'hF, 1'b0), 64'h0, 1'b1);
    cmd("R5", im_insn(3'd7, 4'h9, 1'b0), 64'h0, 1'b1);
    cmd("R5", im_insn(3'd2, 4'h6, 1'b1), 64'h0, 1'b1);
    cmd("R5", im_insn(3'd7, 4'hA, 1'b1), 64'h0, 1'b1);
    idle(2);
    // R6 summary bits: direct write ignored, then sticky/enable drive them
    cmd("R6", rs_insn(1'b0, 8'hFF, 1'b0), 64'h0000_0000_6000_0000, 1'b1);
    cmd("R6", im_insn(3'd1, 4'h1, 1'b0), 64'h0, 1'b1);
    cmd("R6", im_insn(3'd6, 4'h8, 1'b0), 64'h0, 1'b1);
    cmd("R6", im_insn(3'd1, 4'h0, 1'b0), 64'h0, 1'b1);
    cmd("R6", im_insn(3'd0, 4'h9, 1'b0), 64'h0, 1'b1);
    idle(2);
    cmd("R7", rs_insn(1'b0, 8'hFF, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    idle(1);
    cmd("R7", im_insn(3'd4, 4'h7, 1'b0), 64'h0, 1'b0);
    idle(2);
    cmd("R8", im_insn(3'd4, 4'h7, 1'b1), 64'h0, 1'b1);
    idle(2);
    cmd("R9", rs_insn(1'b1, 8'h00, 1'b0), 64'hFFFF_FFFF_0000_0000, 1'b1);
    idle(2);
    // R9 upper half of narrow register stays zero
    check("R9", "narrow upper", {2'b0, st_n[63:32], 32'h0}, 66'h0);
    cmd("R11", 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    cmd("R11", {6'd63, 9'h1FF, 1'b0, 5'd0, 10'd712, 1'b0}, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    cmd("R11", {6'd62, 9'h1FF, 1'b0, 5'd0, 10'd711, 1'b0}, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    idle(2);
    // R10 no change without a strobe
    snap = st_w;
    idle(4);
    check("R10", "idle hold", {st_w, 2'b0}, {snap, 2'b0});
    cmd("R10", rs_insn(1'b0, 8'hF0, 1'b0), 64'h1111_2222_3333_4444, 1'b1);
    cmd("R10", im_insn(3'd3, 4'hC, 1'b0), 64'h0, 1'b1);
    cmd("R10", rs_insn(1'b0, 8'h0F, 1'b1), 64'hABCD_EF01_2345_6789, 1'b1);
    idle(3);
    finish_run();
  end
endmodule